// File: doc/BRIEF.md
# Almost-Flag Offset Register Loader

This block owns the two offset values that a FIFO's flag logic compares against its fill level: an almost-empty offset (X) and an almost-full offset (Y). It decides once, while master reset is held low, how those offsets are filled. It can use a fixed preset of 8, 16 or 64 written to both offsets, two writes from the Port A data bus, or a bit-serial stream clocked in on the Port A clock. The flag comparators read the offsets from the outputs.

The three configuration pins are sampled on every clock edge while master reset is low. Once reset is released, the chosen method stays fixed. A programming-done output tells the rest of the FIFO that the offsets are valid. Port A writes are passed on to the FIFO only after that point. Writes and serial bits that arrive after programming is complete change nothing.

Top module: `flag_offset_loader`

## Requirements
- R1: The method and the preset value are sampled on each rising clock edge while `mrst_n` is low. After `mrst_n` goes high, later changes on `ofs_ser_n`, `dp1_en_n` and `dp0_din` do not change the method or the preset.
- R2: Method encoding is as follows. `ofs_ser_n`=0 selects serial loading. With `ofs_ser_n`=1, the pair {`dp1_en_n`,`dp0_din`} selects: 00 is preset 8, 01 is preset 16, 10 is preset 64, and 11 is parallel loading.
- R3: In preset mode, `x_ofs` and `y_ofs` both equal the selected preset, and `prog_done` is high in the first cycle after `mrst_n` goes high.
- R4: In serial mode, each rising edge with `dp1_en_n`=0 shifts `dp0_din` into the chain, and an edge with `dp1_en_n`=1 shifts nothing. `prog_done` rises after exactly 20 shifted bits.
- R5: The serial chain is {Y,X}, filled MSB first. The first bit becomes `y_ofs[9]` and the 20th bit becomes `x_ofs[0]`.
- R6: In parallel mode, the first `pa_wr` after reset loads `y_ofs` from `pa_data`. The second loads `x_ofs` and raises `prog_done`.
- R7: Once `prog_done` is high, further serial bits and Port A writes leave `x_ofs` and `y_ofs` unchanged.
- R8: `prog_done` is low while `mrst_n` is low. Once high, it stays high until the next master reset.
- R9: `fifo_wr_accept` equals `pa_wr` while `prog_done` is high and is 0 otherwise. This includes the two offset-loading writes in parallel mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port A clock |
| mrst_n | input | 1 | Master reset, active low, synchronous |
| ofs_ser_n | input | 1 | Programming select: 0 = serial, 1 = preset/parallel |
| dp1_en_n | input | 1 | Preset code bit 1 at reset; active-low serial enable afterwards |
| dp0_din | input | 1 | Preset code bit 0 at reset; serial data afterwards |
| pa_wr | input | 1 | Port A write strobe |
| pa_data | input | 10 | Port A data bits used for offset loading |
| x_ofs | output | 10 | Almost-empty offset |
| y_ofs | output | 10 | Almost-full offset |
| prog_done | output | 1 | Offsets valid |
| fifo_wr_accept | output | 1 | Port A write forwarded to the FIFO |

## Verification
The testbench runs each preset code and then toggles the configuration pins after release, which separates pins that are latched at reset from pins that stay live. Serial loads use random 20-bit words with random idle cycles between them, plus two single-one words. The single-one words expose a reversed bit order or swapped halves, and the idle cycles expose an enable that is ignored or inverted. Parallel loads use random data with gaps between the writes, so that a swapped X/Y order or a wrong done count shows up. In every mode, extra bits and writes after completion confirm that the offsets are frozen and that FIFO writes are gated correctly.

// File: rtl/flo_pkg.sv
package flo_pkg;

  typedef enum logic [1:0] {
    METH_PRESET   = 2'd0,
    METH_PARALLEL = 2'd1,
    METH_SERIAL   = 2'd2
  } method_e;

  // Decode of the reset-time configuration pins (R2)
  function automatic method_e pick_method(logic ser_n, logic hi, logic lo);
    if (!ser_n)
      return METH_SERIAL;
    if (hi && lo)
      return METH_PARALLEL;
    return METH_PRESET;
  endfunction

  function automatic int unsigned preset_offset(logic hi, logic lo);
    case ({hi, lo})
      2'b00:   return 8;
      2'b01:   return 16;
      default: return 64;
    endcase
  endfunction

endpackage

// File: rtl/flo_mode_latch.sv
module flo_mode_latch
  import flo_pkg::*;
#(
  parameter int OFS_W = 10
) (
  input  logic             clk,
  input  logic             mrst_n,
  input  logic             ser_n,
  input  logic             pin_hi,
  input  logic             pin_lo,
  output method_e          method,
  output logic [OFS_W-1:0] preset_val
);

  logic sample_ev;
  assign sample_ev = !mrst_n;

  always_ff @(posedge clk) begin
    if (sample_ev) begin
      method     <= pick_method(ser_n, pin_hi, pin_lo);
      preset_val <= OFS_W'(preset_offset(pin_hi, pin_lo));
    end
  end

  assert_method_hold_R1: assert property (@(posedge clk) disable iff (!mrst_n)
    $past(mrst_n) |-> ($stable(method) && $stable(preset_val)));

endmodule

// File: rtl/flo_serial_chain.sv
module flo_serial_chain #(
  parameter int CHAIN_W = 20
) (
  input  logic               clk,
  input  logic               mrst_n,
  input  logic               active,
  input  logic               en_n,
  input  logic               din,
  output logic [CHAIN_W-1:0] chain,
  output logic               full
);

  localparam int CNT_W = $clog2(CHAIN_W + 1);

  logic [CNT_W-1:0] cnt;
  logic             shift_ev;

  assign full     = (cnt == CNT_W'(CHAIN_W));
  assign shift_ev = active && !en_n && !full;

  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      chain <= '0;
      cnt   <= '0;
    end else if (shift_ev) begin
      chain <= {chain[CHAIN_W-2:0], din};
      cnt   <= cnt + 1'b1;
    end
  end

  assert_cnt_limit_R4: assert property (@(posedge clk) disable iff (!mrst_n)
    cnt <= CNT_W'(CHAIN_W));

  assert_shift_entry_R5: assert property (@(posedge clk) disable iff (!mrst_n)
    shift_ev |=> (chain[0] == $past(din)));

  assert_hold_when_full_R7: assert property (@(posedge clk) disable iff (!mrst_n)
    full |=> $stable(chain));

endmodule

// File: rtl/flo_parallel_load.sv
module flo_parallel_load #(
  parameter int OFS_W = 10
) (
  input  logic             clk,
  input  logic             mrst_n,
  input  logic             active,
  input  logic             wr,
  input  logic [OFS_W-1:0] data,
  output logic [OFS_W-1:0] y_val,
  output logic [OFS_W-1:0] x_val,
  output logic             done
);

  logic [1:0] nwr;
  logic       y_ev;
  logic       x_ev;

  assign y_ev = active && wr && (nwr == 2'd0);
  assign x_ev = active && wr && (nwr == 2'd1);
  assign done = (nwr == 2'd2);

  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      nwr   <= 2'd0;
      y_val <= '0;
      x_val <= '0;
    end else begin
      if (y_ev) begin
        y_val <= data;
        nwr   <= 2'd1;
      end
      if (x_ev) begin
        x_val <= data;
        nwr   <= 2'd2;
      end
    end
  end

  assert_y_first_R6: assert property (@(posedge clk) disable iff (!mrst_n)
    y_ev |=> ((y_val == $past(data)) && !done));

  assert_frozen_R7: assert property (@(posedge clk) disable iff (!mrst_n)
    done |=> ($stable(x_val) && $stable(y_val)));

endmodule

// File: rtl/flag_offset_loader.sv
module flag_offset_loader
  import flo_pkg::*;
#(
  parameter int OFS_W = 10
) (
  input  logic             clk,
  input  logic             mrst_n,
  input  logic             ofs_ser_n,
  input  logic             dp1_en_n,
  input  logic             dp0_din,
  input  logic             pa_wr,
  input  logic [OFS_W-1:0] pa_data,
  output logic [OFS_W-1:0] x_ofs,
  output logic [OFS_W-1:0] y_ofs,
  output logic             prog_done,
  output logic             fifo_wr_accept
);

  localparam int CHAIN_W = 2 * OFS_W;

  method_e            method;
  logic [OFS_W-1:0]   preset_val;
  logic [CHAIN_W-1:0] chain;
  logic               ser_full;
  logic [OFS_W-1:0]   par_y;
  logic [OFS_W-1:0]   par_x;
  logic               par_done;
  logic               done_sel;

  flo_mode_latch #(.OFS_W(OFS_W)) u_mode (
    .clk        (clk),
    .mrst_n     (mrst_n),
    .ser_n      (ofs_ser_n),
    .pin_hi     (dp1_en_n),
    .pin_lo     (dp0_din),
    .method     (method),
    .preset_val (preset_val)
  );

  flo_serial_chain #(.CHAIN_W(CHAIN_W)) u_ser (
    .clk    (clk),
    .mrst_n (mrst_n),
    .active (method == METH_SERIAL),
    .en_n   (dp1_en_n),
    .din    (dp0_din),
    .chain  (chain),
    .full   (ser_full)
  );

  flo_parallel_load #(.OFS_W(OFS_W)) u_par (
    .clk    (clk),
    .mrst_n (mrst_n),
    .active (method == METH_PARALLEL),
    .wr     (pa_wr),
    .data   (pa_data),
    .y_val  (par_y),
    .x_val  (par_x),
    .done   (par_done)
  );

  always_comb begin
    case (method)
      METH_SERIAL: begin
        y_ofs    = chain[CHAIN_W-1:OFS_W];
        x_ofs    = chain[OFS_W-1:0];
        done_sel = ser_full;
      end
      METH_PARALLEL: begin
        y_ofs    = par_y;
        x_ofs    = par_x;
        done_sel = par_done;
      end
      default: begin
        y_ofs    = preset_val;
        x_ofs    = preset_val;
        done_sel = 1'b1;
      end
    endcase
  end

  assign prog_done      = mrst_n && done_sel;
  assign fifo_wr_accept = pa_wr && prog_done;

  assert_preset_pair_R3: assert property (@(posedge clk) disable iff (!mrst_n)
    (method == METH_PRESET) |-> ((x_ofs == y_ofs) && prog_done));

  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!mrst_n)
    prog_done |=> prog_done);

endmodule

// File: tb/flag_offset_loader_test.sv
module flag_offset_loader_test;

  localparam int OFS_W = 10;
  localparam int CW    = 2 * OFS_W;

  logic             clk = 1'b0;
  logic             mrst_n;
  logic             ofs_ser_n;
  logic             dp1_en_n;
  logic             dp0_din;
  logic             pa_wr;
  logic [OFS_W-1:0] pa_data;
  logic [OFS_W-1:0] x_ofs;
  logic [OFS_W-1:0] y_ofs;
  logic             prog_done;
  logic             fifo_wr_accept;

  int tests  = 0;
  int fails  = 0;
  bit closed = 1'b0;

  always #10 clk = ~clk;

  flag_offset_loader #(.OFS_W(OFS_W)) uut (
    .clk(clk), .mrst_n(mrst_n), .ofs_ser_n(ofs_ser_n), .dp1_en_n(dp1_en_n),
    .dp0_din(dp0_din), .pa_wr(pa_wr), .pa_data(pa_data), .x_ofs(x_ofs),
    .y_ofs(y_ofs), .prog_done(prog_done), .fifo_wr_accept(fifo_wr_accept)
  );

  function automatic int exp_preset(bit hi, bit lo);
    if (!hi && !lo) return 8;
    if (!hi &&  lo) return 16;
    return 64;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!closed) begin
      closed = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // Master reset with configuration pins; ends at a negedge with reset released
  task automatic master_reset(bit s, bit hi, bit lo);
    @(negedge clk);
    mrst_n = 1'b0; ofs_ser_n = s; dp1_en_n = hi; dp0_din = lo; pa_wr = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8", "done during reset", prog_done, 1'b0);
    mrst_n = 1'b1;
    if (!s) dp1_en_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic serial_run(logic [CW-1:0] bits, bit gaps);
    logic [OFS_W-1:0] xs, ys;
    master_reset(1'b0, 1'b1, 1'b0);
    chk("R4", "done before bits", prog_done, 1'b0);
    for (int i = CW - 1; i >= 0; i--) begin
      if (gaps) begin
        while ($urandom % 3 == 0) begin
          dp1_en_n = 1'b1; dp0_din = 1'($urandom);
          @(negedge clk);
        end
      end
      dp1_en_n = 1'b0; dp0_din = bits[i];
      pa_wr = 1'($urandom);
      #1 chk("R9", "accept before done", fifo_wr_accept, 1'b0);
      @(negedge clk);
      pa_wr = 1'b0;
      if (i == 1) chk("R4", "done after 19 bits", prog_done, 1'b0);
    end
    dp1_en_n = 1'b1;
    chk("R4", "done after 20 bits", prog_done, 1'b1);
    chk("R5", "y from first bits", y_ofs, bits[CW-1:OFS_W]);
    chk("R5", "x from last bits", x_ofs, bits[OFS_W-1:0]);
    xs = x_ofs; ys = y_ofs;
    for (int k = 0; k < 6; k++) begin
      dp1_en_n = 1'b0; dp0_din = ~dp0_din;
      @(negedge clk);
    end
    dp1_en_n = 1'b1;
    chk("R7", "x after extra bits", x_ofs, xs);
    chk("R7", "y after extra bits", y_ofs, ys);
    chk("R8", "done stays high", prog_done, 1'b1);
  endtask

  task automatic parallel_run(logic [OFS_W-1:0] d1, logic [OFS_W-1:0] d2, int gap);
    master_reset(1'b1, 1'b1, 1'b1);
    chk("R6", "done before writes", prog_done, 1'b0);
    pa_wr = 1'b1; pa_data = d1;
    #1 chk("R9", "first write not accepted", fifo_wr_accept, 1'b0);
    @(negedge clk);
    pa_wr = 1'b0;
    chk("R6", "y after first write", y_ofs, d1);
    chk("R6", "done after first write", prog_done, 1'b0);
    repeat (gap) @(negedge clk);
    pa_wr = 1'b1; pa_data = d2;
    #1 chk("R9", "second write not accepted", fifo_wr_accept, 1'b0);
    @(negedge clk);
    pa_wr = 1'b0;
    chk("R6", "x after second write", x_ofs, d2);
    chk("R6", "y kept", y_ofs, d1);
    chk("R6", "done after second write", prog_done, 1'b1);
    pa_wr = 1'b1; pa_data = ~d2;
    #1 chk("R9", "write after done accepted", fifo_wr_accept, 1'b1);
    @(negedge clk);
    pa_wr = 1'b0;
    chk("R7", "x after third write", x_ofs, d2);
    chk("R7", "y after third write", y_ofs, d1);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    mrst_n = 1'b0; ofs_ser_n = 1'b1; dp1_en_n = 1'b0; dp0_din = 1'b0;
    pa_wr = 1'b0; pa_data = '0;

    // Preset codes (R2, R3) and pin changes after release (R1)
    for (int c = 0; c < 3; c++) begin
      bit hi = c[1];
      bit lo = c[0];
      master_reset(1'b1, hi, lo);
      chk("R3", "preset x", x_ofs, exp_preset(hi, lo));
      chk("R3", "preset y", y_ofs, exp_preset(hi, lo));
      chk("R3", "preset done", prog_done, 1'b1);
      for (int k = 0; k < 5; k++) begin
        ofs_ser_n = 1'($urandom); dp1_en_n = 1'($urandom); dp0_din = 1'($urandom);
        @(negedge clk);
      end
      chk("R1", "x after pin toggles", x_ofs, exp_preset(hi, lo));
      chk("R1", "done after pin toggles", prog_done, 1'b1);
      pa_wr = 1'b1;
      #1 chk("R9", "preset write accepted", fifo_wr_accept, 1'b1);
      @(negedge clk);
      pa_wr = 1'b0;
      chk("R7", "preset y after write", y_ofs, exp_preset(hi, lo));
    end

    // Serial: directed bit-order cases then random words with gaps
    serial_run(20'h80000, 1'b0);
    serial_run(20'h00001, 1'b1);
    for (int n = 0; n < 4; n++) serial_run(CW'($urandom), 1'b1);

    // Serial pins changed after release must not switch method (R1)
    master_reset(1'b0, 1'b1, 1'b0);
    ofs_ser_n = 1'b1;
    for (int i = 0; i < CW; i++) begin
      dp1_en_n = 1'b0; dp0_din = 1'b1;
      @(negedge clk);
    end
    dp1_en_n = 1'b1;
    chk("R1", "serial kept after select change", {y_ofs, x_ofs}, 20'hFFFFF);

    // Parallel loads
    parallel_run(10'h3A5, 10'h05A, 0);
    for (int n = 0; n < 4; n++)
      parallel_run(OFS_W'($urandom), OFS_W'($urandom), int'($urandom % 5));

    finish_run();
  end

endmodule